// File: doc/BRIEF.md
# Superframe Signaling Receive Stack

This block sits behind a receive framer that has located the superframe boundary of a 96-channel subscriber-carrier line format. Every superframe carries 36 signaling bits: 12 framing-pattern bits followed by 24 data-link bits (concentrator field, spoilers, maintenance field, alarm field and line-switch field). The block collects those 36 bits one at a time, each marked by a bit strobe. It packs them into a five-byte stack, and that stack is the register image a host reads.

Collection runs only while the framer reports superframe alignment. A superframe-start marker arrives together with the first bit and begins a capture. The bits go into a private shift register. When the 36th bit arrives, the whole word is copied into the host-visible stack in one clock. A ready flag is raised at that point and a one-cycle interrupt pulse fires with it. The host clears the flag by strobing a read. If the host is slow, the next superframe overwrites the stack and the unread contents are lost. When alignment drops, any partial capture is thrown away, and the stack, the flag and the interrupt stay untouched until a fresh superframe start is seen under alignment.

Top module: `slc_rx_stack`

## Requirements
- R1: After reset the stack output is all zeros, and the ready flag and the interrupt are low.
- R2: The stack packs the 36 bits in arrival order. Bits 1..6 go to byte 0 bits 5..0, and bits 7..12 go to byte 1 bits 5..0. Bits 7..6 of those two bytes read zero. Bits 13..36 fill bytes 2, 3 and 4 from bit 7 down to bit 0. Byte 0 is stack_o[39:32] and byte 4 is stack_o[7:0].
- R3: A capture starts only on a strobed bit that has sf_start high while sf_aligned is high. Strobed bits outside a capture are ignored. sf_start without bit_valid is ignored.
- R4: The stack, ready_o and irq_o all change on the clock edge that samples the 36th strobed bit of a capture.
- R5: irq_o is high for exactly one cycle per completed capture.
- R6: A flag_rd strobe clears ready_o on the next edge and leaves the stack unchanged.
- R7: When flag_rd and a capture completion fall on the same edge, ready_o ends high.
- R8: While sf_aligned is low, the stack, ready_o and irq_o do not change. A capture that is interrupted by loss of alignment is discarded and does not resume.
- R9: A completed capture replaces the stack whether or not the previous contents were read.
- R10: The stack changes only on a completion edge, so mid-capture it holds the previous superframe in full.
- R11: An sf_start that arrives during a capture restarts the capture, with that bit as bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received signaling bit |
| bit_valid | input | 1 | Strobe: rx_bit carries a signaling bit this cycle |
| sf_start | input | 1 | First bit of a superframe, valid together with bit_valid |
| sf_aligned | input | 1 | Framer reports superframe alignment |
| flag_rd | input | 1 | Host read strobe that clears the ready flag |
| stack_o | output | 40 | Five-byte receive stack, byte 0 in the top bits |
| ready_o | output | 1 | Receive-stack-ready flag, cleared on read |
| irq_o | output | 1 | One-cycle pulse when a new stack is captured |

## Verification
Every result of this block appears on the first rising edge that samples its cause. The stack, the ready flag and the interrupt appear on the edge that takes the 36th bit. A flag clear appears on the edge that takes flag_rd. The interrupt falls one edge after it rose. The bench drives inputs on falling edges and reads outputs on the falling edge that follows the causing rising edge. It then reads once more one cycle later to confirm the interrupt has dropped. Mid-capture reads taken between bits confirm that the stack still holds the previous superframe.

// File: rtl/slc_rx_pkg.sv
package slc_rx_pkg;
  localparam int SF_BITS     = 36;
  localparam int FS_BITS     = 12;
  localparam int FS_PER_BYTE = 6;
  localparam int BYTE_W      = 8;
  localparam int STACK_BYTES = 5;
  localparam int STACK_W     = BYTE_W * STACK_BYTES;
  localparam int D_BITS      = SF_BITS - FS_BITS;
  localparam int CNT_W       = $clog2(SF_BITS + 1);

  // Map a captured word (first bit in the MSB) onto the stack image.
  function automatic logic [STACK_W-1:0] pack_stack(input logic [SF_BITS-1:0] w);
    logic [STACK_W-1:0] s;
    s = '0;
    for (int k = 0; k < FS_BITS; k++) begin
      s[STACK_W - 1 - BYTE_W*(k / FS_PER_BYTE) - (BYTE_W - FS_PER_BYTE) - (k % FS_PER_BYTE)]
        = w[SF_BITS - 1 - k];
    end
    s[D_BITS-1:0] = w[D_BITS-1:0];
    return s;
  endfunction
endpackage

// File: rtl/slc_rx_collect.sv
module slc_rx_collect
  import slc_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_bit,
  input  logic               bit_valid,
  input  logic               sf_start,
  input  logic               sf_aligned,
  output logic               done_o,
  output logic               discard_o,
  output logic [SF_BITS-1:0] word_o
);
  logic               active_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SF_BITS-1:0] sh_q;
  logic               take_bit;
  logic               last_bit;

  assign take_bit  = sf_aligned && bit_valid && (sf_start || active_q);
  assign last_bit  = active_q && !sf_start && (cnt_q == CNT_W'(SF_BITS - 1));
  assign done_o    = sf_aligned && bit_valid && last_bit;
  assign discard_o = !sf_aligned && active_q;
  assign word_o    = {sh_q[SF_BITS-2:0], rx_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else if (!sf_aligned) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (take_bit) begin
      sh_q <= {sh_q[SF_BITS-2:0], rx_bit};
      if (sf_start) begin
        active_q <= 1'b1;
        cnt_q    <= CNT_W'(1);
      end else if (last_bit) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/slc_rx_commit.sv
module slc_rx_commit
  import slc_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [SF_BITS-1:0] word,
  input  logic               flag_rd,
  output logic [STACK_W-1:0] stack_o,
  output logic               ready_o,
  output logic               irq_o
);
  logic [STACK_W-1:0] image;
  assign image = pack_stack(word);

  for (genvar b = 0; b < STACK_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)      stack_o[b*BYTE_W +: BYTE_W] <= '0;
      else if (commit) stack_o[b*BYTE_W +: BYTE_W] <= image[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= commit;
      if (commit)       ready_o <= 1'b1;
      else if (flag_rd) ready_o <= 1'b0;
    end
  end
endmodule

// File: rtl/slc_rx_stack.sv
module slc_rx_stack
  import slc_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_bit,
  input  logic               bit_valid,
  input  logic               sf_start,
  input  logic               sf_aligned,
  input  logic               flag_rd,
  output logic [STACK_W-1:0] stack_o,
  output logic               ready_o,
  output logic               irq_o
);
  logic               commit_evt;
  logic               discard_evt;
  logic [SF_BITS-1:0] word;

  slc_rx_collect u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_bit     (rx_bit),
    .bit_valid  (bit_valid),
    .sf_start   (sf_start),
    .sf_aligned (sf_aligned),
    .done_o     (commit_evt),
    .discard_o  (discard_evt),
    .word_o     (word)
  );

  slc_rx_commit u_commit (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit_evt),
    .word    (word),
    .flag_rd (flag_rd),
    .stack_o (stack_o),
    .ready_o (ready_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/slc_rx_stack_chk.sv
module slc_rx_stack_chk
  import slc_rx_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               sf_aligned,
  input logic               flag_rd,
  input logic               commit_evt,
  input logic               discard_evt,
  input logic [STACK_W-1:0] stack_o,
  input logic               ready_o,
  input logic               irq_o
);
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  assert_irq_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ready_o);
  assert_flag_rise_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> irq_o);
  assert_stack_only_on_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stack_o) |-> irq_o);
  assert_frozen_unaligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_aligned |=> (!irq_o && $stable(stack_o)));
  assert_discard_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discard_evt |-> !commit_evt);
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !commit_evt) |=> !ready_o);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> ready_o);
endmodule

bind slc_rx_stack slc_rx_stack_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sf_aligned  (sf_aligned),
  .flag_rd     (flag_rd),
  .commit_evt  (commit_evt),
  .discard_evt (discard_evt),
  .stack_o     (stack_o),
  .ready_o     (ready_o),
  .irq_o       (irq_o)
);

// File: tb/slc_rx_stack_bench.sv
module slc_rx_stack_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {36-bit pattern, first bit in MSB ; expected 40-bit stack}
  localparam logic [75:0] VEC [0:NVEC-1] = '{
    {36'hFFFFFFFFF, 40'h3F3FFFFFFF},
    {36'hABCDE1234, 40'h2A3CDE1234},
    {36'h000000000, 40'h0000000000},
    {36'h123456789, 40'h0423456789},
    {36'h5A5A5A5A5, 40'h1625A5A5A5}
  };

  logic        clk = 1'b0;
  logic        rst_n, rx_bit, bit_valid, sf_start, sf_aligned, flag_rd;
  logic [39:0] stack_o;
  logic        ready_o, irq_o;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slc_rx_stack u_slc_rx_stack (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_valid(bit_valid),
    .sf_start(sf_start), .sf_aligned(sf_aligned), .flag_rd(flag_rd),
    .stack_o(stack_o), .ready_o(ready_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [35:0] pat, input int n, input bit start, input bit rd_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1'b1;
      rx_bit    = pat[35-i];
      sf_start  = start && (i == 0);
      flag_rd   = rd_last && (i == n-1);
    end
    @(negedge clk);
    bit_valid = 1'b0; sf_start = 1'b0; flag_rd = 1'b0; rx_bit = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [39:0] prev;
    rst_n = 1'b0; rx_bit = 1'b0; bit_valid = 1'b0; sf_start = 1'b0;
    sf_aligned = 1'b1; flag_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stack", stack_o, 0);
    chk("R1 ready", ready_o, 0);
    chk("R1 irq", irq_o, 0);

    // table walk: packing, completion timing, overwrite without read, mid-capture stability
    prev = '0;
    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][75:40], 18, 1'b1, 1'b0);
      chk("R10 mid-capture stack", stack_o, prev);
      chk("R4 no early irq", irq_o, 0);
      send(VEC[v][75:40] << 18, 18, 1'b0, 1'b0);
      chk("R2/R9 stack", stack_o, VEC[v][39:0]);
      chk("R4 irq", irq_o, 1);
      chk("R4 ready", ready_o, 1);
      @(negedge clk);
      chk("R5 irq drop", irq_o, 0);
      prev = VEC[v][39:0];
    end

    // R6: read clears flag, stack kept
    clear_flag();
    chk("R6 ready cleared", ready_o, 0);
    chk("R6 stack kept", stack_o, prev);

    // R7: read on completion edge
    send(VEC[1][75:40], 36, 1'b1, 1'b1);
    chk("R7 ready stays", ready_o, 1);
    chk("R7 stack", stack_o, VEC[1][39:0]);
    clear_flag();
    prev = VEC[1][39:0];

    // R8: alignment drop mid-capture discards partial
    send(VEC[3][75:40], 20, 1'b1, 1'b0);
    @(negedge clk); sf_aligned = 1'b0;
    @(negedge clk); sf_aligned = 1'b1;
    send(VEC[3][75:40] << 20, 16, 1'b0, 1'b0);
    chk("R8 no irq after drop", irq_o, 0);
    chk("R8 no flag after drop", ready_o, 0);
    chk("R8 stack frozen", stack_o, prev);
    // whole superframe while unaligned
    sf_aligned = 1'b0;
    send(VEC[0][75:40], 36, 1'b1, 1'b0);
    chk("R8 unaligned no irq", irq_o, 0);
    chk("R8 unaligned stack", stack_o, prev);
    sf_aligned = 1'b1;

    // R3: strobed bits without a start are ignored, sf_start without strobe ignored
    send(VEC[4][75:40], 36, 1'b0, 1'b0);
    chk("R3 no capture w/o start", irq_o, 0);
    chk("R3 stack kept", stack_o, prev);
    @(negedge clk); sf_start = 1'b1;
    @(negedge clk); sf_start = 1'b0;
    send(VEC[2][75:40], 35, 1'b0, 1'b0);
    chk("R3 lone marker ignored", stack_o, prev);
    send(VEC[4][75:40], 36, 1'b1, 1'b0);
    chk("R3 capture after start", stack_o, VEC[4][39:0]);
    chk("R3 irq", irq_o, 1);

    // R11: restart on a fresh start mid-capture
    send(VEC[0][75:40], 10, 1'b1, 1'b0);
    chk("R11 no irq partial", irq_o, 0);
    send(VEC[3][75:40], 36, 1'b1, 1'b0);
    chk("R11 restarted stack", stack_o, VEC[3][39:0]);
    chk("R11 irq", irq_o, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule